// File: doc/BRIEF.md
# Machine status control register

This block holds the processor's machine status word: the protection-enable flag and the coprocessor and task flags. Software writes it in two ways and reads it back in one. A status-word load writes only the low 16-bit half. A full control-register write replaces all 32 bits. A status-word store returns the current value. The protection-enable bit is driven out as `mode_is_protected`. The rest of the core uses it to choose between real and protected address translation.

A static `wide_mode` input picks between two personalities. With `wide_mode` low the block acts as the legacy 16-bit status word. Only the four low flags exist, the full-write path is ignored, and protection, once on, cannot be turned off. With `wide_mode` high the block acts as the 32-bit control register. Its extra paging, cache, alignment, write-protect and numeric-error flags are stored but have no effect inside this block. A full write can clear protection and return the core to real mode.

Top module: `mach_ctl_reg`

## Requirements
- R1: After reset every bit of the register is 0 and `mode_is_protected` is 0, which is real mode.
- R2: Defined bit positions are: protection enable 0, coprocessor present 1, emulate coprocessor 2, task switched 3, extension type 4, numeric error 5, write protect 16, alignment mask 18, no write-through 29, cache disable 30, paging 31. This gives an extended-mode mask of 0xE005003F.
- R3: A status-word load (`lsw_we`) changes only defined bits inside bits 15:0. Defined bits 31:16 keep their value.
- R4: Through the status-word load, protection enable can go from 0 to 1, but writing 0 while it is 1 leaves it at 1. This holds in both modes.
- R5: With `wide_mode` high, a full write (`full_we`) sets every defined bit to the written value, including clearing protection enable.
- R6: When a full write and a status-word load fall in the same cycle with `wide_mode` high, only the full write takes effect.
- R7: Reserved bit positions read as 0, whatever value is written to them.
- R8: `mode_is_protected` equals bit 0 of the read value and changes on the clock edge that takes the write.
- R9: With `wide_mode` low, only bits 3:0 are defined. `full_we` is ignored, and `rd_data` shows bits 3:0 with all other bits 0.
- R10: With `wide_mode` high, `rd_data` returns all defined bits of the 32-bit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 = 32-bit control-register personality, 0 = legacy 16-bit |
| lsw_we | input | 1 | Status-word load strobe |
| lsw_data | input | 16 | Status-word load value |
| full_we | input | 1 | Full control-register write strobe |
| full_data | input | 32 | Full write value |
| rd_data | output | 32 | Status-word store value |
| mode_is_protected | output | 1 | Current protection-enable bit |

## Verification
The hardest case to reach is a register that holds protection on together with high-half flags, followed by a status-word load of zero in the same cycle as a full write. To reach it, the stimulus first fills every defined bit with a full write. It then collides a status-word load with a full write, and then sends status-word loads of all ones and all zeros. This shows that the sticky rule, the half-word mask and the priority each act alone. Switching `wide_mode` back to legacy afterwards shows that the stored high flags are hidden but kept.

// File: rtl/mach_ctl_reg.sv
module mach_ctl_reg #(
  parameter int          WIDTH    = 32,
  parameter int          HALF_W   = 16,
  parameter logic [31:0] EXT_MASK = 32'hE005_003F,
  parameter logic [31:0] LEG_MASK = 32'h0000_000F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              lsw_we,
  input  logic [HALF_W-1:0] lsw_data,
  input  logic              full_we,
  input  logic [WIDTH-1:0]  full_data,
  output logic [WIDTH-1:0]  rd_data,
  output logic              mode_is_protected
);

  localparam logic [WIDTH-1:0] HALF_ONES = {{(WIDTH-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [WIDTH-1:0] state_q, state_d, live_mask, half_mask, lsw_ext;
  logic             full_hit;

  assign live_mask = wide_mode ? EXT_MASK[WIDTH-1:0] : LEG_MASK[WIDTH-1:0];
  assign half_mask = live_mask & HALF_ONES;
  assign lsw_ext   = {{(WIDTH-HALF_W){1'b0}}, lsw_data};
  assign full_hit  = full_we && wide_mode;

  always_comb begin
    state_d = state_q;
    if (full_hit) begin
      state_d = full_data & EXT_MASK[WIDTH-1:0];
    end else if (lsw_we) begin
      state_d    = (state_q & ~half_mask) | (lsw_ext & half_mask);
      state_d[0] = state_q[0] | lsw_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign rd_data           = state_q & live_mask;
  assign mode_is_protected = state_q[0];

  AST_PE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lsw_we && !full_hit && mode_is_protected) |=> mode_is_protected); // R4

  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (full_hit && !full_data[0]) |=> !mode_is_protected); // R5

  AST_PE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mode_is_protected == rd_data[0]); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~EXT_MASK[WIDTH-1:0]) == '0); // R7

  AST_LEGACY_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode |-> (rd_data[WIDTH-1:4] == '0)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lsw_we && !full_hit) |=> (!$stable(wide_mode) || $stable(rd_data))); // R3

endmodule

// File: tb/test_mach_ctl_reg.sv
module test_mach_ctl_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic        lsw_we = 1'b0;
  logic [15:0] lsw_data = '0;
  logic        full_we = 1'b0;
  logic [31:0] full_data = '0;
  logic [31:0] rd_data;
  logic        mode_is_protected;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mach_ctl_reg i_mach_ctl_reg (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .lsw_we(lsw_we), .lsw_data(lsw_data),
    .full_we(full_we), .full_data(full_data),
    .rd_data(rd_data), .mode_is_protected(mode_is_protected)
  );

  always @(posedge clk) begin
    #4;
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e || mode_is_protected !== e[0]) begin
        errors++;
        $display("FAIL %s: rd_data=%h prot=%b expected rd_data=%h prot=%b",
                 t, rd_data, mode_is_protected, e, e[0]);
      end
    end
  end

  task automatic op(input bit l, input logic [15:0] ld, input bit f,
                    input logic [31:0] fd, input logic [31:0] e, input string t);
    @(posedge clk);
    #2;
    lsw_we = l; lsw_data = ld; full_we = f; full_data = fd;
    @(posedge clk);
    #1;
    lsw_we = 1'b0; full_we = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: rd_data=%h expected run completion", rd_data);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #20;
    rst_n = 1'b1;
    op(0, 16'h0, 0, 32'h0, 32'h0, "R1 reset zero");
    op(1, 16'h0003, 0, 32'h0, 32'h3, "R2 legacy load PE MP");
    op(1, 16'h0000, 0, 32'h0, 32'h1, "R4 legacy PE sticky");
    op(1, 16'hFFFF, 0, 32'h0, 32'hF, "R7 legacy reserved ignored");
    op(0, 16'h0, 1, 32'h0, 32'hF, "R9 legacy full write ignored");
    @(posedge clk); #2; wide_mode = 1'b1;
    op(0, 16'h0, 0, 32'h0, 32'hF, "R10 extended read");
    op(0, 16'h0, 1, 32'hFFFF_FFFF, 32'hE005_003F, "R2 R7 full ones");
    op(0, 16'h0, 1, 32'h0, 32'h0, "R5 full clear PE");
    op(1, 16'h0030, 0, 32'h0, 32'h30, "R3 load ET NE");
    op(1, 16'h0001, 1, 32'h8000_0000, 32'h8000_0000, "R6 full priority");
    op(1, 16'hFFFF, 0, 32'h0, 32'h8000_003F, "R3 load keeps high");
    op(1, 16'h0000, 0, 32'h0, 32'h8000_0001, "R4 extended PE sticky");
    op(0, 16'h0, 1, 32'h0001_0001, 32'h0001_0001, "R8 full write WP PE");
    op(0, 16'h0, 1, 32'h0001_0000, 32'h0001_0000, "R5 leave protected");
    @(posedge clk); #2; wide_mode = 1'b0;
    op(0, 16'h0, 0, 32'h0, 32'h0, "R9 legacy hides high");
    op(1, 16'h0001, 0, 32'h0, 32'h1, "R8 legacy enter protected");
    @(posedge clk); #2; wide_mode = 1'b1;
    op(0, 16'h0, 0, 32'h0, 32'h0001_0001, "R10 high kept");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule